// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Divider

This unit forms fixed-point ratios of the form dividend / divisor. It splits the work into two operations. A *load* takes an unsigned divisor, scales it into [0.5, 1) by its leading one, seeds a reciprocal estimate with a linear approximation, and refines it with a fixed number of Newton-Raphson steps x ← x·(2 − d·x). The result is kept as a cached reciprocal together with its scale. A *divide* then multiplies a signed dividend by that cached reciprocal and shifts the product to a quotient with 12 fractional bits. Each divide costs one multiply.

The intended use is a calibration loop. The divisor is a reference correlation value that holds for a whole frame, so it is loaded once per frame. Every element's correlation value is then divided by it in turn. A clock-enable input stands in for a gated clock: while it is low, every register in the unit holds its value.

Top module: `nr_recip_div`

## Requirements
- R1: While reset is asserted, busy, done and err are 0 and quotient is 0.
- R2: A load with a nonzero divisor, taken while idle, raises busy on the next cycle and keeps it high for 7 enabled cycles. Done is then high for exactly one cycle, on the 8th enabled edge after the load was sampled. Busy is low while done is high, and err is cleared at that point.
- R3: A divide returns quotient ≈ dividend·4096 / divisor. The quotient is signed and has 12 fractional bits. It lies within 2 + |exact|/2^18 LSB of floor(dividend·4096/divisor), for every divisor from 1 to 65535 and every 16-bit signed dividend.
- R4: A divide taken while idle makes busy high for one cycle. Done and the new quotient appear on the 2nd enabled edge after start was sampled.
- R5: The reciprocal from the last valid load serves every later divide until the next valid load replaces it.
- R6: A load with divisor 0 sets err and pulses done on the next edge, and busy stays low. The cached reciprocal is not changed, so later divides still use the previous divisor.
- R7: Load and start requests made while busy are ignored.
- R8: While clk_en is low, all outputs hold their values, requests are not sampled, and any operation in progress is paused for the number of disabled cycles.
- R9: If load and start are both high in the same idle cycle, the load is taken and the start is dropped. The quotient output keeps its old value.
- R10: A divide issued before any valid load returns a quotient of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes all state |
| load | input | 1 | Request a reciprocal computation from divisor |
| divisor | input | 16 | Unsigned divisor |
| start | input | 1 | Request a divide of dividend by the cached reciprocal |
| dividend | input | 16 | Signed dividend |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last load had a zero divisor |
| quotient | output | 29 | Signed quotient, 12 fractional bits |

## Verification
The divider is exercised with power-of-two divisors, which hit the lower edge of the scaled range where the reciprocal approaches 2. It is also run with 1, 65535 and scattered divisors from a shift-register sequence, together with full-scale positive, full-scale negative, zero and small dividends. These patterns separate errors in the leading-one scaling and in the final shift from errors in the iteration itself. A further set of patterns checks the control path. It issues requests while busy, load and start together, a zero divisor between valid loads, divides before any load, start held high, and enable dropped both mid-computation and while idle. These patterns separate request sampling, priority and reciprocal retention from the arithmetic.

// File: rtl/nr_recip_div.sv
module nr_recip_div #(
  parameter int DW   = 16,
  parameter int FW   = 24,
  parameter int QF   = 12,
  parameter int ITER = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic                 load,
  input  logic [DW-1:0]        divisor,
  input  logic                 start,
  input  logic signed [DW-1:0] dividend,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic signed [DW+QF:0] quotient
);
  localparam int XW = FW + 2;
  localparam int PW = $clog2(DW) + 1;
  localparam int IW = $clog2(ITER) + 1;
  localparam int MW = XW + FW;
  localparam logic [XW-1:0] ONE  = XW'(64'd1 << FW);
  localparam logic [XW-1:0] TWO  = XW'(64'd2 << FW);
  localparam logic [XW-1:0] SEED_A = XW'((64'd48 << FW) / 17);
  localparam logic [XW-1:0] SEED_B = XW'((64'd32 << FW) / 17);

  typedef enum logic [2:0] {S_IDLE, S_NORM, S_EST, S_UPD, S_MUL} st_t;
  st_t st;

  logic [DW-1:0]        d_r;
  logic signed [DW-1:0] a_r;
  logic [FW-1:0]        dn_r, dn_c;
  logic [XW-1:0]        x_r, e_r, recip, seed, e_c, x_n;
  logic [PW-1:0]        sh_r, rsh, lead;
  logic [IW-1:0]        it;
  logic                 rvld;
  logic [MW-1:0]        seed_p, dx_p;
  logic [2*XW-1:0]      xe_p;
  logic signed [DW+XW:0] q_p, q_s;

  always_comb begin
    lead = '0;
    for (int i = 0; i < DW; i++)
      if (d_r[i]) lead = PW'(i);
  end

  assign dn_c   = FW'(d_r) << (FW - 1 - int'(lead));
  assign seed_p = MW'(SEED_B) * MW'(dn_c);
  assign seed   = SEED_A - XW'(seed_p >> FW);
  assign dx_p   = MW'(dn_r) * MW'(x_r);
  assign e_c    = TWO - XW'(dx_p >> FW);
  assign xe_p   = (2*XW)'(x_r) * (2*XW)'(e_r);
  assign x_n    = XW'(xe_p >> FW);
  assign q_p    = a_r * $signed({1'b0, recip});
  assign q_s    = q_p >>> (FW + int'(rsh) - QF);
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  d_r <= '0;  a_r <= '0;  dn_r <= '0;
      x_r <= '0;  e_r <= '0;  recip <= '0;  sh_r <= '0;  rsh <= '0;
      it <= '0;  rvld <= 1'b0;  done <= 1'b0;  err <= 1'b0;  quotient <= '0;
    end else if (clk_en) begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (load) begin
            if (divisor == '0) begin
              err  <= 1'b1;
              done <= 1'b1;
            end else begin
              d_r <= divisor;
              st  <= S_NORM;
            end
          end else if (start) begin
            a_r <= dividend;
            st  <= S_MUL;
          end
        S_NORM: begin
          x_r  <= seed;
          dn_r <= dn_c;
          sh_r <= lead + PW'(1);
          it   <= '0;
          st   <= S_EST;
        end
        S_EST: begin
          e_r <= e_c;
          st  <= S_UPD;
        end
        S_UPD: begin
          x_r <= x_n;
          if (it == IW'(ITER - 1)) begin
            recip <= x_n;
            rsh   <= sh_r;
            rvld  <= 1'b1;
            err   <= 1'b0;
            done  <= 1'b1;
            st    <= S_IDLE;
          end else begin
            it <= it + IW'(1);
            st <= S_EST;
          end
        end
        S_MUL: begin
          quotient <= q_s[DW+QF:0];
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clk_en && !load) |=> !done);

  // R3
  recip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvld |-> (recip >= ONE - XW'(64) && recip <= TWO));

  // R6
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !busy && load && divisor == '0) |=> ($stable(recip) && err && done && !busy));

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(quotient) && $stable(busy) && $stable(done) && $stable(err)));
endmodule

// File: tb/nr_recip_div_test.sv
module nr_recip_div_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic load = 1'b0;
  logic start = 1'b0;
  logic [15:0] divisor = '0;
  logic signed [15:0] dividend = '0;
  logic busy, done, err;
  logic signed [28:0] quotient;

  nr_recip_div uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .load(load), .divisor(divisor),
    .start(start), .dividend(dividend), .busy(busy), .done(done), .err(err),
    .quotient(quotient)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  string cur_req = "R1";
  bit running = 1'b0;

  int     m_cnt = 0;
  int     m_op = 0;
  bit     m_busy = 0, m_done = 0, m_err = 0;
  longint m_D = 0, m_q = 0, p_D = 0, p_a = 0;

  function automatic longint ideal(longint a, longint d);
    longint n, r;
    if (d == 0) return 0;
    n = a * 4096;
    r = n / d;
    if (n < 0 && (n % d) != 0) r = r - 1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_done = 0; m_err = 0; m_D = 0; m_q = 0;
    end else if (clk_en) begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          if (m_op == 1) begin m_D = p_D; m_err = 0; end
          else m_q = ideal(p_a, m_D);
        end
      end else if (load) begin
        if (divisor == 0) begin m_err = 1; m_done = 1; end
        else begin m_cnt = 7; m_op = 1; p_D = longint'(divisor); end
      end else if (start) begin
        m_cnt = 1; m_op = 2; p_a = longint'(dividend);
      end
      m_busy = (m_cnt > 0);
    end
  end

  always @(negedge clk) begin
    if (running && rst_n) begin
      longint q, d, tol;
      q = longint'(quotient);
      d = q - m_q;
      if (d < 0) d = -d;
      tol = 2 + ((m_q < 0 ? -m_q : m_q) >>> 18);
      chk(busy == m_busy, "busy", busy, m_busy);
      chk(done == m_done, "done", done, m_done);
      chk(err == m_err, "err", err, m_err);
      chk(d <= tol, "quotient", q, m_q);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [15:0] d);
    load = 1'b1; divisor = d;
    cyc(1);
    load = 1'b0;
    cyc(8);
  endtask

  task automatic do_div(input logic signed [15:0] a);
    start = 1'b1; dividend = a;
    cyc(1);
    start = 1'b0;
    cyc(2);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    cyc(3);
    cur_req = "R1";
    chk(busy == 1'b0, "reset busy", busy, 0);
    chk(done == 1'b0, "reset done", done, 0);
    chk(err == 1'b0, "reset err", err, 0);
    chk(quotient == '0, "reset quotient", quotient, 0);
    rst_n = 1'b1;
    running = 1'b1;
    cyc(2);

    cur_req = "R10";
    do_div(16'sd1000);
    chk(quotient == '0, "quotient before load", quotient, 0);

    cur_req = "R2";
    do_load(16'd3);
    cur_req = "R3";
    do_div(16'sd1000);
    do_div(-16'sd1000);
    do_div(16'sd32767);
    do_div(-16'sd32768);
    do_div(16'sd0);
    do_div(16'sd7);

    cur_req = "R5";
    do_load(16'd65535);
    do_div(16'sd32767);
    do_div(-16'sd12345);
    do_load(16'd1);
    do_div(-16'sd32768);
    do_div(16'sd32767);
    do_load(16'd32768);
    do_div(16'sd32767);
    do_div(-16'sd3);
    do_load(16'd12345);
    do_div(16'sd22222);

    cur_req = "R6";
    do_load(16'd0);
    do_div(16'sd22222);
    do_div(-16'sd9999);
    do_load(16'd4);
    do_div(16'sd100);

    cur_req = "R7";
    load = 1'b1; divisor = 16'd200;
    cyc(1);
    load = 1'b0;
    cyc(2);
    start = 1'b1; dividend = 16'sd5; load = 1'b1; divisor = 16'd0;
    cyc(2);
    start = 1'b0; load = 1'b0;
    cyc(6);
    do_div(16'sd30000);

    cur_req = "R9";
    load = 1'b1; divisor = 16'd9; start = 1'b1; dividend = 16'sd77;
    cyc(1);
    load = 1'b0; start = 1'b0;
    cyc(8);
    do_div(16'sd77);

    cur_req = "R8";
    load = 1'b1; divisor = 16'd300;
    cyc(1);
    load = 1'b0;
    cyc(2);
    clk_en = 1'b0; start = 1'b1; dividend = 16'sd11;
    cyc(5);
    start = 1'b0; clk_en = 1'b1;
    cyc(7);
    clk_en = 1'b0; start = 1'b1; dividend = 16'sd500;
    cyc(3);
    start = 1'b0; clk_en = 1'b1;
    cyc(3);
    do_div(16'sd500);

    cur_req = "R4";
    start = 1'b1;
    for (int k = 0; k < 6; k++) begin
      dividend = 16'(k * 4001 - 9000);
      cyc(1);
    end
    start = 1'b0;
    cyc(3);

    cur_req = "R3";
    for (int k = 0; k < 30; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf != 16'd0) do_load(lf);
      do_div($signed(lf ^ 16'h5A5A));
      do_div($signed(~lf));
      do_div(16'sd1);
    end

    cyc(2);
    finish_run();
  end
endmodule